// File: doc/BRIEF.md
# TDD rate-matching byte buffer

This block sits between a byte stream that moves at a fixed, continuous rate and a time-division-duplex line that can carry traffic only while a periodic active window is open. It holds two independent buffers. The transmit buffer takes one byte at every slow-rate opportunity. Whenever the window is open, it gives one symbol at every fast-rate opportunity. The receive buffer takes fast-rate bursts during the window and gives one byte at every slow-rate opportunity. Neither buffer looks for packet boundaries. Each one carries a plain, unbroken byte stream, so frames of any length pass through.

Both rates share one clock. A slow enable (`slowEn`) marks the continuous-rate slots and a fast enable (`fastEn`) marks the burst-rate slots. Each burst-side symbol has a ninth bit that marks it as idle fill. The transmit side sends idle fill when it has no data in a window slot. The receive side drops incoming idle fill so that it never reaches its buffer. The buffer depth is a parameter, sized as the silent interval times the slow rate. A 10 µs gap at 100 Mb/s gives 125 bytes, which is the default. After reset, the receive side withholds output until its fill level first reaches a programmable start level. Sticky error flags report a lost byte or a missed delivery.

Top module: `tdd_rate_buffer`

## Requirements
- R1: On a cycle with `slowEn` and `txInValid` high, `txInData` is stored in the transmit buffer unless the buffer is full and is not read in the same cycle. `txCount` rises by one at the next clock edge, less any read in the same cycle.
- R2: On every cycle with `fastEn` and `activeWin` high, `txOutValid` is high in the following cycle. Stored bytes leave in write order, one per such slot. On any other cycle `txOutValid` is low in the following cycle.
- R3: If a transmit slot finds the buffer empty, the symbol is idle fill: `txOutIdle` is 1 and `txOutData` is 0x00. A data symbol has `txOutIdle` = 0.
- R4: The receive buffer stores `rxInData` only on a cycle where `fastEn`, `activeWin` and `rxInValid` are all 1 and `rxInIdle` is 0. Idle symbols and bytes offered outside the window leave `rxCount` unchanged.
- R5: After reset, no receive byte is delivered until `rxCount` has been at least `rxThresh` on some clock edge. From the next cycle on, every `slowEn` cycle is a mandatory read.
- R6: A mandatory read of a non-empty receive buffer makes `rxOutValid` high for one cycle, one cycle after the `slowEn` cycle. The bytes come out in arrival order.
- R7: A write to a full buffer that is not read in the same cycle drops the byte. It sets the sticky flag for that direction (`txOverflow` or `rxOverflow`), and the flag stays set until reset.
- R8: A mandatory receive read that finds the buffer empty sets the sticky flag `rxUnderflow`, and `rxOutValid` stays low for that slot.
- R9: After reset both counts are 0 and all flags are 0. A count never exceeds DEPTH.
- R10: Every 8-bit value passes through both directions unchanged, including 0x00 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both rates |
| rst_n | input | 1 | Active-low synchronous reset |
| slowEn | input | 1 | Continuous-rate slot enable |
| fastEn | input | 1 | Burst-rate slot enable |
| activeWin | input | 1 | Active window of the duplex schedule |
| txInValid | input | 1 | Continuous-side transmit byte present |
| txInData | input | DATA_W | Continuous-side transmit byte |
| txOutValid | output | 1 | Burst-side transmit symbol present |
| txOutIdle | output | 1 | Transmit symbol is idle fill |
| txOutData | output | DATA_W | Transmit symbol byte (0x00 when idle) |
| txCount | output | CNT_W | Transmit buffer fill level |
| txOverflow | output | 1 | Sticky transmit overflow |
| rxInValid | input | 1 | Burst-side receive symbol present |
| rxInIdle | input | 1 | Receive symbol is idle fill |
| rxInData | input | DATA_W | Receive symbol byte |
| rxThresh | input | CNT_W | Fill level that starts receive delivery |
| rxOutValid | output | 1 | Continuous-side receive byte present |
| rxOutData | output | DATA_W | Continuous-side receive byte |
| rxCount | output | CNT_W | Receive buffer fill level |
| rxOverflow | output | 1 | Sticky receive overflow |
| rxUnderflow | output | 1 | Sticky receive underflow |

## Verification
A pointer or count that goes wrong inside either buffer shows up at the ports within one cycle. The count output moves out of step with the slots that were offered, or the next byte delivered does not match the write order. A bad start latch shows up as receive bytes that appear before the start level was reached, or that never appear after it. A bad fill-versus-data decision shows up on the very next window slot as a flipped idle flag or a non-zero idle byte. A broken flag shows up on the cycle after the first lost byte or missed delivery.

// File: rtl/tdd_rb_pkg.sv
package tdd_rb_pkg;
  // Strobes from the control to one buffer datapath for one cycle
  typedef struct packed {
    logic push;  // store the incoming byte
    logic pop;   // remove the head byte and present it
    logic emit;  // an output slot occurs (data or fill)
  } fifoStb_t;
endpackage

// File: rtl/rb_fifo.sv
module rb_fifo
  import tdd_rb_pkg::*;
#(
  parameter int DEPTH  = 125,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fifoStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (stb.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      if (stb.push) wrPtr <= advance(wrPtr);
      if (stb.pop)  rdPtr <= advance(rdPtr);
      unique case ({stb.push, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      outValid <= stb.emit;
      outData  <= stb.pop ? store[rdPtr] : '0;
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import tdd_rb_pkg::*;
#(
  parameter int DEPTH = 125,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slowEn,
  input  logic             fastEn,
  input  logic             activeWin,
  input  logic             txInValid,
  input  logic             rxInValid,
  input  logic             rxInIdle,
  input  logic [CNT_W-1:0] rxThresh,
  input  logic             txFull,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic             rxEmpty,
  input  logic [CNT_W-1:0] rxCount,
  output fifoStb_t         txStb,
  output fifoStb_t         rxStb,
  output logic             txIdleFlag,
  output logic             txOvf,
  output logic             rxOvf,
  output logic             rxUdf
);
  logic burstSlot;
  logic rxStarted;
  logic txWant, rxWant, rxMustRead;
  logic txOvfEvt, rxOvfEvt, rxUdfEvt;

  always_comb begin
    burstSlot  = fastEn & activeWin;
    txWant     = slowEn & txInValid;
    rxWant     = burstSlot & rxInValid & ~rxInIdle;
    rxMustRead = slowEn & rxStarted;

    txStb.emit = burstSlot;
    txStb.pop  = burstSlot & ~txEmpty;
    txStb.push = txWant & (~txFull | txStb.pop);
    txOvfEvt   = txWant & txFull & ~txStb.pop;

    rxStb.pop  = rxMustRead & ~rxEmpty;
    rxStb.emit = rxStb.pop;
    rxStb.push = rxWant & (~rxFull | rxStb.pop);
    rxOvfEvt   = rxWant & rxFull & ~rxStb.pop;
    rxUdfEvt   = rxMustRead & rxEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxStarted  <= 1'b0;
      txIdleFlag <= 1'b0;
      txOvf      <= 1'b0;
      rxOvf      <= 1'b0;
      rxUdf      <= 1'b0;
    end else begin
      rxStarted  <= rxStarted | (rxCount >= rxThresh);
      txIdleFlag <= burstSlot & txEmpty;
      txOvf      <= txOvf | txOvfEvt;
      rxOvf      <= rxOvf | rxOvfEvt;
      rxUdf      <= rxUdf | rxUdfEvt;
    end
  end
endmodule

// File: rtl/tdd_rate_buffer.sv
module tdd_rate_buffer
  import tdd_rb_pkg::*;
#(
  parameter int DEPTH  = 125,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slowEn,
  input  logic              fastEn,
  input  logic              activeWin,
  input  logic              txInValid,
  input  logic [DATA_W-1:0] txInData,
  output logic              txOutValid,
  output logic              txOutIdle,
  output logic [DATA_W-1:0] txOutData,
  output logic [CNT_W-1:0]  txCount,
  output logic              txOverflow,
  input  logic              rxInValid,
  input  logic              rxInIdle,
  input  logic [DATA_W-1:0] rxInData,
  input  logic [CNT_W-1:0]  rxThresh,
  output logic              rxOutValid,
  output logic [DATA_W-1:0] rxOutData,
  output logic [CNT_W-1:0]  rxCount,
  output logic              rxOverflow,
  output logic              rxUnderflow
);
  fifoStb_t txStb, rxStb;
  logic txFull, txEmpty, rxFull, rxEmpty;

  rb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .slowEn(slowEn), .fastEn(fastEn),
    .activeWin(activeWin), .txInValid(txInValid), .rxInValid(rxInValid),
    .rxInIdle(rxInIdle), .rxThresh(rxThresh), .txFull(txFull),
    .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .rxCount(rxCount), .txStb(txStb), .rxStb(rxStb),
    .txIdleFlag(txOutIdle), .txOvf(txOverflow), .rxOvf(rxOverflow),
    .rxUdf(rxUnderflow)
  );

  rb_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_txBuf (
    .clk(clk), .rst_n(rst_n), .stb(txStb), .wrData(txInData),
    .outValid(txOutValid), .outData(txOutData), .count(txCount),
    .full(txFull), .empty(txEmpty)
  );

  rb_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rxBuf (
    .clk(clk), .rst_n(rst_n), .stb(rxStb), .wrData(rxInData),
    .outValid(rxOutValid), .outData(rxOutData), .count(rxCount),
    .full(rxFull), .empty(rxEmpty)
  );
endmodule

// File: rtl/tdd_rb_chk.sv
module tdd_rb_chk #(
  parameter int DEPTH  = 125,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slowEn,
  input logic              fastEn,
  input logic              activeWin,
  input logic              txOutValid,
  input logic              txOutIdle,
  input logic [DATA_W-1:0] txOutData,
  input logic [CNT_W-1:0]  txCount,
  input logic              txOverflow,
  input logic              rxInValid,
  input logic              rxInIdle,
  input logic              rxOutValid,
  input logic [CNT_W-1:0]  rxCount,
  input logic              rxOverflow,
  input logic              rxUnderflow
);
  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txCount <= CNT_W'(DEPTH)) && (rxCount <= CNT_W'(DEPTH)));
  // R2
  tx_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txOutValid |-> $past(fastEn && activeWin));
  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txOutValid && txOutIdle) |-> (txOutData == '0));
  // R4
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxCount > $past(rxCount)) |-> $past(fastEn && activeWin && rxInValid && !rxInIdle));
  // R6
  rx_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxOutValid |-> $past(slowEn));
  // R7
  tx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txOverflow |=> txOverflow);
  // R7
  rx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxOverflow |=> rxOverflow);
  // R8
  rx_udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxUnderflow |=> rxUnderflow);
endmodule

bind tdd_rate_buffer tdd_rb_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slowEn(slowEn), .fastEn(fastEn),
  .activeWin(activeWin), .txOutValid(txOutValid), .txOutIdle(txOutIdle),
  .txOutData(txOutData), .txCount(txCount), .txOverflow(txOverflow),
  .rxInValid(rxInValid), .rxInIdle(rxInIdle), .rxOutValid(rxOutValid),
  .rxCount(rxCount), .rxOverflow(rxOverflow), .rxUnderflow(rxUnderflow)
);

// File: tb/sim_tdd_rate_buffer.sv
module sim_tdd_rate_buffer;
  localparam int DEPTH = 125;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slowEn = 0, fastEn = 0, activeWin = 0;
  logic txInValid = 0, rxInValid = 0, rxInIdle = 0;
  logic [DW-1:0] txInData = '0, rxInData = '0;
  logic [CW-1:0] rxThresh = '0;
  logic txOutValid, txOutIdle, txOverflow, rxOutValid, rxOverflow, rxUnderflow;
  logic [DW-1:0] txOutData, rxOutData;
  logic [CW-1:0] txCount, rxCount;

  always #2.5 clk = ~clk;

  tdd_rate_buffer #(.DEPTH(DEPTH), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .slowEn(slowEn), .fastEn(fastEn),
    .activeWin(activeWin), .txInValid(txInValid), .txInData(txInData),
    .txOutValid(txOutValid), .txOutIdle(txOutIdle), .txOutData(txOutData),
    .txCount(txCount), .txOverflow(txOverflow), .rxInValid(rxInValid),
    .rxInIdle(rxInIdle), .rxInData(rxInData), .rxThresh(rxThresh),
    .rxOutValid(rxOutValid), .rxOutData(rxOutData), .rxCount(rxCount),
    .rxOverflow(rxOverflow), .rxUnderflow(rxUnderflow)
  );

  int nChecks = 0, nErrors = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] txQ[$], rxQ[$];
  bit eTxOvf, eRxOvf, eRxUdf, eStarted;
  bit eTxValid, eTxIdle, eRxValid;
  logic [DW-1:0] eTxData, eRxData;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit txSlot();
    return fastEn && activeWin;
  endfunction

  task automatic clearModel();
    txQ.delete(); rxQ.delete();
    eTxOvf = 0; eRxOvf = 0; eRxUdf = 0; eStarted = 0;
  endtask

  // one clock: predict from the inputs now applied, advance, compare
  task automatic step();
    bit tp, rp, rw, tw, mustRead;
    logic [DW-1:0] tHead, rHead;
    tp = txSlot() && (txQ.size() > 0);
    tw = slowEn && txInValid;
    mustRead = slowEn && eStarted;
    rp = mustRead && (rxQ.size() > 0);
    rw = txSlot() && rxInValid && !rxInIdle;
    tHead = '0; rHead = '0;
    eTxValid = txSlot();
    eTxIdle  = txSlot() && !tp;
    if (mustRead && rxQ.size() == 0) eRxUdf = 1;
    if (rxQ.size() >= int'(rxThresh)) eStarted = 1;
    if (tp) tHead = txQ.pop_front();
    if (tw) begin
      if (txQ.size() >= DEPTH) eTxOvf = 1; else txQ.push_back(txInData);
    end
    if (rp) rHead = rxQ.pop_front();
    if (rw) begin
      if (rxQ.size() >= DEPTH) eRxOvf = 1; else rxQ.push_back(rxInData);
    end
    eTxData = tHead; eRxData = rHead; eRxValid = rp;
    @(posedge clk); #1;
    check("R2 txOutValid", txOutValid, eTxValid);
    check("R3 txOutIdle", txOutIdle, eTxIdle);
    check("R2 R10 txOutData", txOutData, eTxData);
    check("R5 R6 rxOutValid", rxOutValid, eRxValid);
    check("R6 R10 rxOutData", rxOutData, eRxData);
    check("R1 R9 txCount", txCount, txQ.size());
    check("R4 R9 rxCount", rxCount, rxQ.size());
    check("R7 txOverflow", txOverflow, eTxOvf);
    check("R7 rxOverflow", rxOverflow, eRxOvf);
    check("R8 rxUnderflow", rxUnderflow, eRxUdf);
  endtask

  task automatic quiet();
    slowEn = 0; fastEn = 0; activeWin = 0;
    txInValid = 0; rxInValid = 0; rxInIdle = 0;
  endtask

  task automatic doReset(input logic [CW-1:0] th);
    quiet(); rxThresh = th; rst_n = 0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1; clearModel();
  endtask

  initial begin
    void'($urandom(32'd20240712));
    #1;
    doReset(CW'(8));
    // R9: reset state
    check("R9 reset txCount", txCount, 0);
    check("R9 reset rxCount", rxCount, 0);
    check("R9 reset flags", {txOverflow, rxOverflow, rxUnderflow}, 0);

    // nominal schedule with random data and random idle gaps on receive
    begin
      int backlog = 0;
      for (int c = 0; c < 64 * 40; c++) begin
        int ph = c % 64;
        slowEn    = (ph % 4) == 0;
        fastEn    = 1;
        activeWin = ph >= 32;
        txInValid = slowEn;
        txInData  = DW'($urandom);
        if (slowEn) backlog++;
        rxInValid = activeWin;
        rxInIdle  = !(activeWin && backlog > 0 && ($urandom % 10) < 8);
        rxInData  = DW'($urandom);
        step();
        if (activeWin && !rxInIdle) backlog--;
      end
    end

    // R3: empty transmit buffer in an open window gives idle fill
    doReset(CW'(8));
    fastEn = 1; activeWin = 1;
    step();
    check("R3 idle flag on empty slot", txOutIdle, 1);
    check("R3 idle byte is 0x00", txOutData, 0);

    // R10: extreme values through transmit
    quiet(); slowEn = 1; txInValid = 1;
    txInData = 8'h00; step();
    txInData = 8'hFF; step();
    quiet(); fastEn = 1; activeWin = 1;
    step();
    check("R10 0x00 data not idle", txOutIdle, 0);
    step();
    check("R10 0xFF passes", txOutData, 8'hFF);

    // R4: receive bytes outside the window or marked idle are dropped
    quiet(); fastEn = 1; rxInValid = 1; rxInData = 8'h5A; step();
    check("R4 out-of-window ignored", rxCount, 0);
    activeWin = 1; rxInIdle = 1; step();
    check("R4 idle discarded", rxCount, 0);

    // R5: hold delivery below start level of 4
    doReset(CW'(4));
    for (int k = 0; k < 3; k++) begin
      quiet(); fastEn = 1; activeWin = 1; rxInValid = 1; rxInData = DW'(8'hA0 + k);
      step();
    end
    for (int k = 0; k < 4; k++) begin
      quiet(); slowEn = 1; step();
      check("R5 withheld below start level", rxOutValid, 0);
    end
    quiet(); fastEn = 1; activeWin = 1; rxInValid = 1; rxInData = 8'hA3; step();
    quiet(); step();          // start latch sets on this edge
    quiet(); slowEn = 1; step();
    check("R5 delivery after start", rxOutValid, 1);
    check("R6 first byte in order", rxOutData, 8'hA0);

    // R8: start level 0 with an empty buffer underflows on first read
    doReset(CW'(0));
    quiet(); step();
    slowEn = 1; step();
    check("R8 underflow raised", rxUnderflow, 1);
    check("R8 no byte delivered", rxOutValid, 0);
    quiet(); repeat (3) step();
    check("R8 underflow sticky", rxUnderflow, 1);

    // R7: overflow on both sides with no reads
    doReset(CW'(DEPTH + 2 > (1 << CW) - 1 ? (1 << CW) - 1 : DEPTH + 2));
    for (int k = 0; k < DEPTH + 1; k++) begin
      quiet(); slowEn = 1; txInValid = 1; txInData = DW'(k);
      step();
    end
    check("R7 tx count capped", txCount, DEPTH);
    check("R7 tx overflow set", txOverflow, 1);
    for (int k = 0; k < DEPTH + 1; k++) begin
      quiet(); fastEn = 1; activeWin = 1; rxInValid = 1; rxInData = DW'(k);
      step();
    end
    check("R7 rx count capped", rxCount, DEPTH);
    check("R7 rx overflow set", rxOverflow, 1);
    // drain transmit: the dropped byte must not appear
    for (int k = 0; k < DEPTH + 2; k++) begin
      quiet(); fastEn = 1; activeWin = 1; step();
    end
    check("R7 tx overflow sticky", txOverflow, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule